// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block sits in the pixel path of a display controller and paints a small hardware cursor over the picture. A 64x64 cursor image, two bits per cursor pixel, is held in local storage. While the raster is inside the cursor window, each cursor code is turned into a colour by the selected decoding mode. The result is the underlying pixel, one of three cursor colours, or the bitwise inverse of the underlying pixel. Outside the active display area the block emits a programmable border (overscan) colour.

Software programs the block through a byte-wide indexed write port. The control byte, the staged cursor position, a small colour file reached through an auto-stepping index, and the cursor image reached through an auto-stepping address pointer all sit behind this port. Register indices: 0 control, 1 colour index, 2 colour data, 3 image address low byte, 4 image address high byte, 5 image data, 6 X low, 7 X high, 8 Y low, 9 Y high. Control byte fields: bits [1:0] mode, bit 4 wide blanking extent, bit 5 interlaced, bit 6 field polarity invert.

Top module: `cursor_overlay_mixer`

## Requirements
- R1: While rst_n is low, pix_out is 0; after reset the control byte, all colours, both pointers and the live and staged positions are 0.
- R2: With mode bits [1:0] = 00 the output equals pix_in one clock later, the same one-register latency as every other path.
- R3: Mode 01: inside the window, codes 0,1,2,3 give pix_in, colour entry 1, entry 2 and entry 3.
- R4: Mode 10: inside the window, code 0 gives entry 1, code 1 gives entry 2, code 2 gives pix_in and code 3 gives the bitwise inverse of pix_in.
- R5: Mode 11: inside the window, codes 0 and 1 give pix_in, code 2 gives entry 1 and code 3 gives entry 2.
- R6: When pix_active is low the output is colour entry 0 (overscan); an active pixel outside the 64x64 window passes pix_in unchanged.
- R7: A write to index 1 sets the colour index from data bits [1:0]; each write to index 2 stores the byte at that index and steps it, wrapping from 3 to 0.
- R8: Position bytes written at indices 6 to 9 are staged and become the live cursor position only at a clock edge where frame_start is high.
- R9: Index 3 and 4 set the low and high bytes of the image pointer; each write to index 5 stores the byte there and steps the pointer, wrapping from the last byte (1023) to 0. Cursor pixel (x, y) is bits [2k+1:2k] of byte y*16 + x/4, with k = x mod 4.
- R10: With control bit 4 clear, raster X and cursor X are compared modulo 2048; with bit 4 set, the full 12-bit values are compared.
- R11: With control bit 5 set, the line compared against cursor Y is 2*pix_y + (pix_field XOR control bit 6), taken modulo 4096.
- R12: Writes to indices 10 to 15 change neither the control byte, the colours, the pointers, the positions nor the image.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | Frame boundary pulse; loads the staged position |
| pix_active | input | 1 | High inside the active display area |
| pix_field | input | 1 | Current interlace field |
| pix_x | input | POS_W | Raster column |
| pix_y | input | POS_W | Raster row |
| pix_in | input | PIX_W | Underlying pixel |
| pix_out | output | PIX_W | Mixed pixel, one clock after its inputs |

## Verification
The bench builds the block at its defaults: 8-bit pixels, 12-bit positions and a 64x64 cursor, giving a 1024-byte image. The 12-bit position puts raster columns on both sides of 2048 within reach, so the narrow and wide blanking extents give different answers for the same cursor. The 1024-byte image is small enough to fill completely and wrap the pointer. Every decoding mode is swept across window edges with a filled image that holds all four codes, and interlaced lines are driven in both fields with both polarities.

// File: rtl/curmix_pkg.sv
package curmix_pkg;

   typedef enum logic [1:0] {
      CM_OFF  = 2'd0,
      CM_TRI  = 2'd1,
      CM_XGA  = 2'd2,
      CM_XWIN = 2'd3
   } cm_mode_e;

   typedef struct packed {
      logic     spare7;
      logic     field_inv;
      logic     interlace;
      logic     wide_blank;
      logic [1:0] spare32;
      cm_mode_e mode;
   } cm_ctrl_t;

   localparam logic [3:0] IDX_CTRL  = 4'd0;
   localparam logic [3:0] IDX_CPTR  = 4'd1;
   localparam logic [3:0] IDX_CDATA = 4'd2;
   localparam logic [3:0] IDX_IALO  = 4'd3;
   localparam logic [3:0] IDX_IAHI  = 4'd4;
   localparam logic [3:0] IDX_IDATA = 4'd5;
   localparam logic [3:0] IDX_XLO   = 4'd6;
   localparam logic [3:0] IDX_XHI   = 4'd7;
   localparam logic [3:0] IDX_YLO   = 4'd8;
   localparam logic [3:0] IDX_YHI   = 4'd9;

endpackage

// File: rtl/curmix_regs.sv
module curmix_regs
   import curmix_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int POS_W  = 12,
   parameter int IMG_AW = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [3:0]             reg_idx,
   input  logic [7:0]             reg_wdata,
   input  logic                   frame_start,
   output cm_ctrl_t               ctrl,
   output logic [3:0][PIX_W-1:0]  clr_file,
   output logic [POS_W-1:0]       cur_x,
   output logic [POS_W-1:0]       cur_y,
   output logic                   img_we,
   output logic [IMG_AW-1:0]      img_waddr,
   output logic [7:0]             img_wdata
);

   logic [POS_W-1:0]  x_stage, y_stage;
   logic [15:0]       xs16, ys16, ip16;
   logic [1:0]        cptr;
   logic [IMG_AW-1:0] iptr;

   logic wr_ctrl, wr_cptr, wr_cdata, wr_ialo, wr_iahi, wr_idata;
   logic wr_xlo, wr_xhi, wr_ylo, wr_yhi;

   assign wr_ctrl  = reg_we && (reg_idx == IDX_CTRL);
   assign wr_cptr  = reg_we && (reg_idx == IDX_CPTR);
   assign wr_cdata = reg_we && (reg_idx == IDX_CDATA);
   assign wr_ialo  = reg_we && (reg_idx == IDX_IALO);
   assign wr_iahi  = reg_we && (reg_idx == IDX_IAHI);
   assign wr_idata = reg_we && (reg_idx == IDX_IDATA);
   assign wr_xlo   = reg_we && (reg_idx == IDX_XLO);
   assign wr_xhi   = reg_we && (reg_idx == IDX_XHI);
   assign wr_ylo   = reg_we && (reg_idx == IDX_YLO);
   assign wr_yhi   = reg_we && (reg_idx == IDX_YHI);

   assign xs16 = 16'(x_stage);
   assign ys16 = 16'(y_stage);
   assign ip16 = 16'(iptr);

   // control byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl <= '0;
      else if (wr_ctrl) ctrl <= cm_ctrl_t'(reg_wdata);
   end

   // staged and live cursor position
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_stage <= '0;
         y_stage <= '0;
         cur_x   <= '0;
         cur_y   <= '0;
      end else begin
         if (frame_start) begin
            cur_x <= x_stage;
            cur_y <= y_stage;
         end
         if (wr_xlo) x_stage <= POS_W'({xs16[15:8], reg_wdata});
         if (wr_xhi) x_stage <= POS_W'({reg_wdata, xs16[7:0]});
         if (wr_ylo) y_stage <= POS_W'({ys16[15:8], reg_wdata});
         if (wr_yhi) y_stage <= POS_W'({reg_wdata, ys16[7:0]});
      end
   end

   // colour index, steps after each data write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cptr <= '0;
      else if (wr_cptr)  cptr <= reg_wdata[1:0];
      else if (wr_cdata) cptr <= cptr + 2'd1;
   end

   for (genvar k = 0; k < 4; k++) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                clr_file[k] <= '0;
         else if (wr_cdata && (cptr == 2'(k)))      clr_file[k] <= reg_wdata[PIX_W-1:0];
      end
   end

   // image pointer, wraps through the power-of-two depth
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        iptr <= '0;
      else if (wr_ialo)  iptr <= IMG_AW'({ip16[15:8], reg_wdata});
      else if (wr_iahi)  iptr <= IMG_AW'({reg_wdata, ip16[7:0]});
      else if (wr_idata) iptr <= iptr + IMG_AW'(1);
   end

   assign img_we    = wr_idata;
   assign img_waddr = iptr;
   assign img_wdata = reg_wdata;

endmodule

// File: rtl/curmix_image.sv
module curmix_image #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/curmix_blend.sv
module curmix_blend
   import curmix_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int POS_W   = 12,
   parameter int CUR_DIM = 64,
   parameter int IMG_AW  = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  cm_mode_e               mode,
   input  logic                   wide_blank,
   input  logic                   interlace,
   input  logic                   field_inv,
   input  logic [3:0][PIX_W-1:0]  clr_file,
   input  logic [POS_W-1:0]       cur_x,
   input  logic [POS_W-1:0]       cur_y,
   input  logic                   pix_active,
   input  logic                   pix_field,
   input  logic [POS_W-1:0]       pix_x,
   input  logic [POS_W-1:0]       pix_y,
   input  logic [PIX_W-1:0]       pix_in,
   input  logic [7:0]             img_rdata,
   output logic [IMG_AW-1:0]      img_raddr,
   output logic [PIX_W-1:0]       pix_out
);

   localparam int CD_W   = $clog2(CUR_DIM);
   localparam int NARROW = 11;

   logic [POS_W-1:0] px_e, cx_e, line;
   logic [POS_W:0]   dx, dy;
   logic             in_win;
   logic [CD_W-1:0]  ox, oy;
   logic [1:0]       code;
   logic [PIX_W-1:0] mixed;

   // horizontal blanking extent: narrow compares modulo 2**NARROW
   if (POS_W > NARROW) begin : g_extent
      localparam logic [POS_W-1:0] NARROW_MASK = POS_W'((1 << NARROW) - 1);
      assign px_e = wide_blank ? pix_x : (pix_x & NARROW_MASK);
      assign cx_e = wide_blank ? cur_x : (cur_x & NARROW_MASK);
   end else begin : g_no_extent
      assign px_e = pix_x;
      assign cx_e = cur_x;
   end

   assign line = interlace ? {pix_y[POS_W-2:0], pix_field ^ field_inv} : pix_y;

   assign dx = {1'b0, px_e} - {1'b0, cx_e};
   assign dy = {1'b0, line} - {1'b0, cur_y};

   assign in_win = !dx[POS_W] && (dx[POS_W-1:0] < POS_W'(CUR_DIM)) &&
                   !dy[POS_W] && (dy[POS_W-1:0] < POS_W'(CUR_DIM));

   assign ox = dx[CD_W-1:0];
   assign oy = dy[CD_W-1:0];

   // four cursor pixels per byte, leftmost in the low bits
   assign img_raddr = {oy, ox[CD_W-1:2]};
   assign code      = img_rdata[{ox[1:0], 1'b0} +: 2];

   always_comb begin
      mixed = pix_in;
      if (in_win) begin
         unique case (mode)
            CM_OFF:  mixed = pix_in;
            CM_TRI:  if (code != 2'd0) mixed = clr_file[code];
            CM_XGA: begin
               unique case (code)
                  2'd0:    mixed = clr_file[1];
                  2'd1:    mixed = clr_file[2];
                  2'd2:    mixed = pix_in;
                  default: mixed = ~pix_in;
               endcase
            end
            CM_XWIN: if (code[1]) mixed = clr_file[{code[0], ~code[0]}];
            default: mixed = pix_in;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pix_out <= '0;
      else if (!pix_active) pix_out <= clr_file[0];
      else                 pix_out <= mixed;
   end

endmodule

// File: rtl/cursor_overlay_mixer.sv
module cursor_overlay_mixer
   import curmix_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int POS_W   = 12,
   parameter int CUR_DIM = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [3:0]       reg_idx,
   input  logic [7:0]       reg_wdata,
   input  logic             frame_start,
   input  logic             pix_active,
   input  logic             pix_field,
   input  logic [POS_W-1:0] pix_x,
   input  logic [POS_W-1:0] pix_y,
   input  logic [PIX_W-1:0] pix_in,
   output logic [PIX_W-1:0] pix_out
);

   localparam int IMG_DEPTH = (CUR_DIM * CUR_DIM) / 4;
   localparam int IMG_AW    = $clog2(IMG_DEPTH);

   if (PIX_W < 1 || PIX_W > 8) begin : g_bad_pix
      $error("PIX_W must lie in 1..8");
   end
   if (POS_W < 12 || POS_W > 16) begin : g_bad_pos
      $error("POS_W must lie in 12..16");
   end
   if (CUR_DIM < 4 || (CUR_DIM & (CUR_DIM - 1)) != 0) begin : g_bad_dim
      $error("CUR_DIM must be a power of two, at least 4");
   end

   cm_ctrl_t               ctrl_q;
   logic [3:0][PIX_W-1:0]  clr_file;
   logic [POS_W-1:0]       cur_x_live, cur_y_live;
   logic                   img_we;
   logic [IMG_AW-1:0]      img_waddr, img_raddr;
   logic [7:0]             img_wdata, img_rdata;

   curmix_regs #(
      .PIX_W (PIX_W),
      .POS_W (POS_W),
      .IMG_AW(IMG_AW)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_idx    (reg_idx),
      .reg_wdata  (reg_wdata),
      .frame_start(frame_start),
      .ctrl       (ctrl_q),
      .clr_file   (clr_file),
      .cur_x      (cur_x_live),
      .cur_y      (cur_y_live),
      .img_we     (img_we),
      .img_waddr  (img_waddr),
      .img_wdata  (img_wdata)
   );

   curmix_image #(
      .DEPTH(IMG_DEPTH),
      .AW   (IMG_AW)
   ) u_image (
      .clk  (clk),
      .we   (img_we),
      .waddr(img_waddr),
      .wdata(img_wdata),
      .raddr(img_raddr),
      .rdata(img_rdata)
   );

   curmix_blend #(
      .PIX_W  (PIX_W),
      .POS_W  (POS_W),
      .CUR_DIM(CUR_DIM),
      .IMG_AW (IMG_AW)
   ) u_blend (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (ctrl_q.mode),
      .wide_blank(ctrl_q.wide_blank),
      .interlace (ctrl_q.interlace),
      .field_inv (ctrl_q.field_inv),
      .clr_file  (clr_file),
      .cur_x     (cur_x_live),
      .cur_y     (cur_y_live),
      .pix_active(pix_active),
      .pix_field (pix_field),
      .pix_x     (pix_x),
      .pix_y     (pix_y),
      .pix_in    (pix_in),
      .img_rdata (img_rdata),
      .img_raddr (img_raddr),
      .pix_out   (pix_out)
   );

endmodule

// File: rtl/cursor_overlay_mixer_chk.sv
module cursor_overlay_mixer_chk #(
   parameter int PIX_W = 8,
   parameter int POS_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [3:0]       reg_idx,
   input logic             frame_start,
   input logic             pix_active,
   input logic [PIX_W-1:0] pix_in,
   input logic [PIX_W-1:0] pix_out,
   input logic [7:0]       ctrl_byte,
   input logic [PIX_W-1:0] overscan,
   input logic [POS_W-1:0] cur_x,
   input logic [POS_W-1:0] cur_y
);

   // R1: reset holds the output at zero
   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |=> (pix_out == '0));

   // R2: disabled mode forwards the pixel with one register of latency
   a_r2_off_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_active && ctrl_byte[1:0] == 2'b00) |=> (pix_out == $past(pix_in)));

   // R6: outside the active area the overscan colour is shown
   a_r6_overscan: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_active |=> (pix_out == $past(overscan)));

   // R8: the live position moves only on a frame boundary
   a_r8_pos_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(cur_x) && $stable(cur_y)));

   // R12: the control byte changes only through its own index
   a_r12_ctrl_only_own_index: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_idx == 4'd0) |=> $stable(ctrl_byte));

endmodule

bind cursor_overlay_mixer cursor_overlay_mixer_chk #(
   .PIX_W(PIX_W),
   .POS_W(POS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_idx    (reg_idx),
   .frame_start(frame_start),
   .pix_active (pix_active),
   .pix_in     (pix_in),
   .pix_out    (pix_out),
   .ctrl_byte  (ctrl_q),
   .overscan   (clr_file[0]),
   .cur_x      (cur_x_live),
   .cur_y      (cur_y_live)
);

// File: tb/cursor_overlay_mixer_tb.sv
module cursor_overlay_mixer_tb;

   localparam int PIX_W = 8;
   localparam int POS_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_we = 1'b0;
   logic [3:0]       reg_idx = '0;
   logic [7:0]       reg_wdata = '0;
   logic             frame_start = 1'b0;
   logic             pix_active = 1'b0;
   logic             pix_field = 1'b0;
   logic [POS_W-1:0] pix_x = '0;
   logic [POS_W-1:0] pix_y = '0;
   logic [PIX_W-1:0] pix_in = '0;
   logic [PIX_W-1:0] pix_out;

   always #5 clk = ~clk;

   cursor_overlay_mixer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_idx    (reg_idx),
      .reg_wdata  (reg_wdata),
      .frame_start(frame_start),
      .pix_active (pix_active),
      .pix_field  (pix_field),
      .pix_x      (pix_x),
      .pix_y      (pix_y),
      .pix_in     (pix_in),
      .pix_out    (pix_out)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit have_exp = 1'b0;
   int exp_val = 0;
   string exp_tag = "R1";
   string phase = "R1";

   // behavioural reference state
   int m_ctrl, m_cptr, m_iptr, m_xs, m_ys, m_xl, m_yl;
   int m_clr [4];
   int m_img [1024];

   initial begin
      for (int i = 0; i < 1024; i++) m_img[i] = 0;
   end

   function automatic int predict(output string t);
      int mode, px, cx, ly, dx, dy, code, pin;
      mode = m_ctrl & 3;
      pin  = int'(pix_in);
      if (!pix_active) begin t = "R6"; return m_clr[0]; end
      if (mode == 0)   begin t = "R2"; return pin; end
      px = ((m_ctrl & 16) != 0) ? int'(pix_x) : int'(pix_x) % 2048;
      cx = ((m_ctrl & 16) != 0) ? m_xl : m_xl % 2048;
      if ((m_ctrl & 32) != 0)
         ly = (2 * int'(pix_y) + (int'(pix_field) ^ ((m_ctrl >> 6) & 1))) % 4096;
      else
         ly = int'(pix_y);
      dx = px - cx;
      dy = ly - m_yl;
      if (dx < 0 || dx >= 64 || dy < 0 || dy >= 64) begin t = "R6"; return pin; end
      code = (m_img[dy * 16 + dx / 4] >> (2 * (dx % 4))) & 3;
      case (mode)
         1: begin
            t = "R3";
            return (code == 0) ? pin : m_clr[code];
         end
         2: begin
            t = "R4";
            case (code)
               0: return m_clr[1];
               1: return m_clr[2];
               2: return pin;
               default: return (~pin) & 255;
            endcase
         end
         default: begin
            t = "R5";
            if (code < 2) return pin;
            return (code == 2) ? m_clr[1] : m_clr[2];
         end
      endcase
   endfunction

   always @(posedge clk) begin
      string t;
      int wd;
      if (!rst_n) begin
         m_ctrl = 0; m_cptr = 0; m_iptr = 0;
         m_xs = 0; m_ys = 0; m_xl = 0; m_yl = 0;
         for (int k = 0; k < 4; k++) m_clr[k] = 0;
         exp_val = 0;
         exp_tag = "R1";
      end else begin
         exp_val = predict(t);
         exp_tag = (phase != "") ? phase : t;
         if (frame_start) begin
            m_xl = m_xs;
            m_yl = m_ys;
         end
         if (reg_we) begin
            wd = int'(reg_wdata);
            case (int'(reg_idx))
               0: m_ctrl = wd;
               1: m_cptr = wd & 3;
               2: begin m_clr[m_cptr] = wd; m_cptr = (m_cptr + 1) % 4; end
               3: m_iptr = (m_iptr & 'h300) | wd;
               4: m_iptr = ((wd & 3) << 8) | (m_iptr & 255);
               5: begin m_img[m_iptr] = wd; m_iptr = (m_iptr + 1) % 1024; end
               6: m_xs = (m_xs & 'hF00) | wd;
               7: m_xs = ((wd & 15) << 8) | (m_xs & 255);
               8: m_ys = (m_ys & 'hF00) | wd;
               9: m_ys = ((wd & 15) << 8) | (m_ys & 255);
               default: ;
            endcase
         end
      end
      have_exp = 1'b1;
   end

   always @(negedge clk) begin
      if (have_exp && !done) begin
         checks++;
         if (int'(pix_out) != exp_val) begin
            errors++;
            $display("FAIL %s: pix_out actual %0h expected %0h at %0t",
                     exp_tag, pix_out, exp_val, $time);
         end
      end
   end

   task automatic wr(input int idx, input int d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_idx   = 4'(idx);
      reg_wdata = 8'(d);
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic px_at(input bit act, input int x, input int y, input int f);
      @(negedge clk);
      pix_active = act;
      pix_x      = POS_W'(x);
      pix_y      = POS_W'(y);
      pix_field  = f[0];
      pix_in     = PIX_W'((x * 13 + y * 7 + f * 91) & 255);
   endtask

   task automatic sweep(input int y, input int x0, input int n, input int f);
      for (int i = 0; i < n; i++) px_at(1'b1, x0 + i, y, f);
   endtask

   task automatic frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: output held at zero in reset
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      phase = "";

      // R2 and R6: disabled mode, then border pixels
      sweep(10, 0, 40, 0);
      for (int i = 0; i < 5; i++) px_at(1'b0, i, 10, 0);

      // R7: colour file loading with index wrap onto the overscan entry
      phase = "R7";
      wr(1, 0);
      wr(2, 'h11);
      wr(2, 'h5A);
      wr(2, 'hA5);
      wr(2, 'hC3);
      wr(2, 'h22);
      for (int i = 0; i < 4; i++) px_at(1'b0, i, 0, 0);
      wr(1, 2);
      wr(2, 'h77);
      for (int i = 0; i < 3; i++) px_at(1'b0, i, 0, 0);

      // R9: fill the image, then wrap the pointer back to byte 0
      phase = "R9";
      wr(3, 0);
      wr(4, 0);
      for (int i = 0; i < 1024; i++) wr(5, (i * 37 + 11) & 255);
      wr(5, 'hE4);
      wr(3, 'h10);
      wr(4, 0);
      wr(5, 'h1B);
      wr(0, 1);
      sweep(0, 0, 70, 0);
      sweep(1, 0, 70, 0);

      // R8: staged position takes effect only at the frame pulse
      phase = "R8";
      wr(6, 100);
      wr(7, 0);
      wr(8, 50);
      wr(9, 0);
      sweep(2, 0, 70, 0);
      sweep(52, 90, 20, 0);
      frame();
      sweep(52, 90, 20, 0);
      sweep(2, 0, 10, 0);
      phase = "";

      // R3, R4, R5: each decoding mode across the window edges
      for (int m = 1; m < 4; m++) begin
         wr(0, m);
         for (int row = 47; row < 118; row += 7) sweep(row, 95, 75, 0);
      end

      // R10: blanking extent with a cursor beyond column 2048
      phase = "R10";
      wr(6, 200);
      wr(7, 8);
      frame();
      wr(0, 'h01);
      sweep(60, 190, 80, 0);
      sweep(60, 2240, 80, 0);
      wr(0, 'h11);
      sweep(60, 190, 80, 0);
      sweep(60, 2240, 80, 0);

      // R11: interlaced line mapping, both fields and both polarities
      phase = "R11";
      wr(6, 100);
      wr(7, 0);
      frame();
      wr(0, 'h21);
      sweep(25, 95, 75, 0);
      sweep(25, 95, 75, 1);
      sweep(40, 95, 75, 0);
      sweep(56, 95, 75, 1);
      wr(0, 'h61);
      sweep(25, 95, 75, 0);
      sweep(25, 95, 75, 1);
      wr(0, 'h62);
      sweep(30, 95, 75, 1);

      // R12: writes to unused indices leave every setting intact
      phase = "R12";
      wr(0, 1);
      for (int idx = 10; idx < 16; idx++) wr(idx, 'hFF);
      sweep(60, 95, 75, 0);
      for (int i = 0; i < 4; i++) px_at(1'b0, i, 0, 0);
      wr(5, 'h00);
      wr(3, 'h10);
      wr(2, 'h3C);
      sweep(50, 95, 75, 0);
      for (int i = 0; i < 4; i++) px_at(1'b0, i, 0, 0);

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule